// File: doc/BRIEF.md
# Gated frequency measurement sequencer

This block runs one frequency measurement on a counter that sits behind a register-access port. After a start pulse it selects the input to be measured, arms and clears the counter, and opens the counting gate. It waits for the requested gate time and closes the gate. It then reads the 16-bit count as two bytes, restores the selection bits, and divides to produce a scaled frequency value.

The counter does not perform full register writes. It accepts bit-level set and clear operations and byte reads on a request/acknowledge port, so the block never needs a copy of the remote register contents. The gate time is given in milliseconds. The block shortens it by a fixed 16 microseconds to cover the bus traffic around the gate. Counts taken from the main FM oscillator are multiplied by 256 before the division.

Top module: `freq_meas_seq`

## Requirements
- R1: During and right after reset, `reg_req_o`, `result_valid_o` and `busy_o` are low.
- R2: `start_i` is accepted only while `busy_o` is low. Source, scale and duration are captured at acceptance. A start pulse or any input change while busy has no effect on the operations issued or on the result.
- R3: The opening operations are issued in this order:
  - SET in register 0x02 of the source bit. `src_sel_i` 0 maps to bit 0 (IF), 1 to bit 1 (FM) and 2 to bit 2 (stereo-decoder clock).
  - CLR of mask 0x02 in register 0x06.
  - SET of mask 0x80 in register 0x12.
  - SET of mask 0x80 in register 0x06.
  - CLR of mask 0x80 in register 0x06.
  - SET of mask 0x04 in register 0x06.
- R4: An operation is presented with `reg_req_o` high. Its op code (0 = SET, 1 = CLR, 2 = READ), address and mask stay stable until `reg_ack_i`. Each acknowledge consumes exactly one operation. READ operations carry mask 0.
- R5: From the clock edge that acknowledges the gate-open operation to the edge that raises the gate-close request (CLR of mask 0x04 in register 0x06), exactly (duration × 1000 − 16) × CLK_HZ/1e6 clock cycles pass.
- R6: After the gate closes, register 0x0B is read, then register 0x0A. The count is {first byte, second byte}.
- R7: After readout, the block issues CLR of mask 0x80 in register 0x12, then CLR of the source bit in register 0x02.
- R8: For source FM the result is floor(scale × count × 256 / duration). For the other sources it is floor(scale × count / duration).
- R9: `result_valid_o` is a single-cycle pulse. It occurs NUM_W cycles after the final acknowledge, once the sequential divider finishes. `result_o` holds its value until the next pulse.
- R10: `busy_o` is high from the cycle after acceptance through the cycle of `result_valid_o`. `reg_req_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one measurement |
| src_sel_i | input | 2 | Source: 0 IF, 1 FM, 2 stereo-decoder clock |
| scale_i | input | SCALE_W | Scale factor |
| dur_ms_i | input | DUR_W | Gate duration in milliseconds, at least 1 |
| busy_o | output | 1 | Measurement in progress |
| reg_req_o | output | 1 | Register operation request |
| reg_op_o | output | 2 | 0 SET bits, 1 CLR bits, 2 READ |
| reg_addr_o | output | 8 | Register address |
| reg_mask_o | output | 8 | Bit mask for SET/CLR |
| reg_ack_i | input | 1 | Operation done; read data valid |
| reg_rdata_i | input | 8 | Read data, sampled with the acknowledge |
| result_o | output | NUM_W | Scaled frequency result |
| result_valid_o | output | 1 | Result strobe |

## Verification
The assertions rely on a few input conditions:
- The duration is never zero when a measurement starts.
- `src_sel_i` never takes the reserved value 3.
- The counter side raises `reg_ack_i` only while a request is pending, with read data valid in that cycle.

The stimulus only starts measurements with durations from 1 to 7 ms and sources 0 to 2. Its register model acknowledges a request only after the request has been seen low-acknowledged for a cycle, one operation per pulse. Inputs are scrambled only while the block is busy, and those values must be ignored.

// File: rtl/fms_pkg.sv
package fms_pkg;
    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_READ = 2'd2
    } reg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GATE,
        ST_DIV
    } seq_state_e;

    localparam int STEP_W         = 4;
    localparam int STEP_GATE_OPEN = 5;
    localparam int STEP_READ_HI   = 7;
    localparam int STEP_READ_LO   = 8;
    localparam int STEP_LAST      = 10;
    localparam int SRC_FM         = 1;
endpackage

// File: rtl/fms_step_decode.sv
module fms_step_decode
    import fms_pkg::*;
#(
    parameter logic [7:0] SRC_ADDR   = 8'h02,
    parameter logic [7:0] CTRL_ADDR  = 8'h06,
    parameter logic [7:0] RADIO_ADDR = 8'h12,
    parameter logic [7:0] HI_ADDR    = 8'h0B,
    parameter logic [7:0] LO_ADDR    = 8'h0A
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [7:0]        src_mask_i,
    output reg_op_e           op_o,
    output logic [7:0]        addr_o,
    output logic [7:0]        mask_o
);
    localparam logic [7:0] M_SELECT = 8'h02;
    localparam logic [7:0] M_CLEAR  = 8'h80;
    localparam logic [7:0] M_GATE   = 8'h04;
    localparam logic [7:0] M_MEAS   = 8'h80;

    always_comb begin
        op_o   = OP_SET;
        addr_o = SRC_ADDR;
        mask_o = src_mask_i;
        case (step_i)
            4'd0:  begin op_o = OP_SET;  addr_o = SRC_ADDR;   mask_o = src_mask_i; end
            4'd1:  begin op_o = OP_CLR;  addr_o = CTRL_ADDR;  mask_o = M_SELECT;   end
            4'd2:  begin op_o = OP_SET;  addr_o = RADIO_ADDR; mask_o = M_MEAS;     end
            4'd3:  begin op_o = OP_SET;  addr_o = CTRL_ADDR;  mask_o = M_CLEAR;    end
            4'd4:  begin op_o = OP_CLR;  addr_o = CTRL_ADDR;  mask_o = M_CLEAR;    end
            4'd5:  begin op_o = OP_SET;  addr_o = CTRL_ADDR;  mask_o = M_GATE;     end
            4'd6:  begin op_o = OP_CLR;  addr_o = CTRL_ADDR;  mask_o = M_GATE;     end
            4'd7:  begin op_o = OP_READ; addr_o = HI_ADDR;    mask_o = 8'h00;      end
            4'd8:  begin op_o = OP_READ; addr_o = LO_ADDR;    mask_o = 8'h00;      end
            4'd9:  begin op_o = OP_CLR;  addr_o = RADIO_ADDR; mask_o = M_MEAS;     end
            4'd10: begin op_o = OP_CLR;  addr_o = SRC_ADDR;   mask_o = src_mask_i; end
            default: begin op_o = OP_READ; addr_o = 8'h00; mask_o = 8'h00; end
        endcase
    end
endmodule

// File: rtl/fms_gate_timer.sv
module fms_gate_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int DUR_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [DUR_W-1:0] dur_ms_i,
    output logic             done_o
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int PRE_W      = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam int US_W       = DUR_W + 10;

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [US_W-1:0]  us;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [US_W-1:0] target;
    logic            us_tick;
    logic            last_us;

    always_comb begin
        target  = US_W'(dur_ms_i) * US_W'(1000) - US_W'(16);
        us_tick = (tmr_q.pre == PRE_W'(CYC_PER_US - 1));
        last_us = (tmr_q.us == target - US_W'(1));
        done_o  = tmr_q.run && us_tick && last_us;

        tmr_d = tmr_q;
        if (go_i) begin
            tmr_d.run = 1'b1;
            tmr_d.pre = '0;
            tmr_d.us  = '0;
        end else if (tmr_q.run) begin
            if (us_tick) begin
                tmr_d.pre = '0;
                if (last_us) tmr_d.run = 1'b0;
                else         tmr_d.us  = tmr_q.us + US_W'(1);
            end else begin
                tmr_d.pre = tmr_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assert_gate_not_retriggered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !tmr_q.run);
    assert_gate_runs_until_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && !done_o) |=> tmr_q.run);
endmodule

// File: rtl/fms_divider.sv
module fms_divider #(
    parameter int NUM_W = 40,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NUM_W-1:0] dividend_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quotient_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] dvs;
        logic [DIV_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [NUM_W-1:0] res;
    } div_t;

    div_t div_d, div_q;
    logic [DIV_W:0] trial;
    logic           fits;

    always_comb begin
        trial = {div_q.rem, div_q.quo[NUM_W-1]};
        fits  = (trial >= {1'b0, div_q.dvs});

        div_d      = div_q;
        div_d.done = 1'b0;
        if (go_i) begin
            div_d.run = 1'b1;
            div_d.cnt = CNT_W'(NUM_W);
            div_d.dvs = divisor_i;
            div_d.rem = '0;
            div_d.quo = dividend_i;
        end else if (div_q.run) begin
            div_d.rem = fits ? DIV_W'(trial - {1'b0, div_q.dvs}) : DIV_W'(trial);
            div_d.quo = {div_q.quo[NUM_W-2:0], fits};
            div_d.cnt = div_q.cnt - CNT_W'(1);
            if (div_q.cnt == CNT_W'(1)) begin
                div_d.run  = 1'b0;
                div_d.done = 1'b1;
                div_d.res  = {div_q.quo[NUM_W-2:0], fits};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done_o     = div_q.done;
    assign quotient_o = div_q.res;

    assert_divisor_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (divisor_i != '0));
    assert_remainder_below_divisor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.run |-> (div_q.rem < div_q.dvs));
endmodule

// File: rtl/freq_meas_seq.sv
module freq_meas_seq
    import fms_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int SCALE_W = 16,
    parameter int DUR_W   = 8,
    parameter int NUM_W   = SCALE_W + 16 + 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         src_sel_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [DUR_W-1:0]   dur_ms_i,
    output logic               busy_o,
    output logic               reg_req_o,
    output logic [1:0]         reg_op_o,
    output logic [7:0]         reg_addr_o,
    output logic [7:0]         reg_mask_o,
    input  logic               reg_ack_i,
    input  logic [7:0]         reg_rdata_i,
    output logic [NUM_W-1:0]   result_o,
    output logic               result_valid_o
);
    localparam int CNT_W = 16;

    typedef struct packed {
        seq_state_e         st;
        logic [STEP_W-1:0]  step;
        logic [1:0]         src;
        logic [SCALE_W-1:0] scale;
        logic [DUR_W-1:0]   dur;
        logic [CNT_W-1:0]   cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic             timer_go, timer_done;
    logic             div_go, div_done;
    logic [NUM_W-1:0] product, numerator;
    logic [7:0]       src_mask;
    reg_op_e          step_op;

    assign src_mask = 8'(1) << ctl_q.src;

    fms_step_decode u_decode (
        .step_i     (ctl_q.step),
        .src_mask_i (src_mask),
        .op_o       (step_op),
        .addr_o     (reg_addr_o),
        .mask_o     (reg_mask_o)
    );

    always_comb begin
        ctl_d    = ctl_q;
        timer_go = 1'b0;
        div_go   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: if (start_i) begin
                ctl_d.st    = ST_ISSUE;
                ctl_d.step  = '0;
                ctl_d.src   = src_sel_i;
                ctl_d.scale = scale_i;
                ctl_d.dur   = dur_ms_i;
            end
            ST_ISSUE: if (reg_ack_i) begin
                if (ctl_q.step == STEP_W'(STEP_READ_HI)) ctl_d.cnt[15:8] = reg_rdata_i;
                if (ctl_q.step == STEP_W'(STEP_READ_LO)) ctl_d.cnt[7:0]  = reg_rdata_i;
                ctl_d.step = ctl_q.step + STEP_W'(1);
                if (ctl_q.step == STEP_W'(STEP_GATE_OPEN)) begin
                    ctl_d.st = ST_GATE;
                    timer_go = 1'b1;
                end else if (ctl_q.step == STEP_W'(STEP_LAST)) begin
                    ctl_d.st = ST_DIV;
                    div_go   = 1'b1;
                end
            end
            ST_GATE: if (timer_done) ctl_d.st = ST_ISSUE;
            ST_DIV:  if (div_done)   ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign product   = NUM_W'(ctl_q.scale) * NUM_W'(ctl_q.cnt);
    assign numerator = (ctl_q.src == 2'(SRC_FM)) ? (product << 8) : product;

    fms_gate_timer #(.CLK_HZ(CLK_HZ), .DUR_W(DUR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (timer_go),
        .dur_ms_i (ctl_q.dur),
        .done_o   (timer_done)
    );

    fms_divider #(.NUM_W(NUM_W), .DIV_W(DUR_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_go),
        .dividend_i (numerator),
        .divisor_i  (ctl_q.dur),
        .done_o     (div_done),
        .quotient_o (result_o)
    );

    assign busy_o         = (ctl_q.st != ST_IDLE);
    assign reg_req_o      = (ctl_q.st == ST_ISSUE);
    assign reg_op_o       = step_op;
    assign result_valid_o = div_done;

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_op_o)
                                       && $stable(reg_addr_o) && $stable(reg_mask_o)));
    assert_ack_only_on_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_ack_i |-> reg_req_o);
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);
    assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> $stable(result_o));
    assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !reg_req_o);
    assert_valid_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> (busy_o && !reg_req_o));
    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !result_valid_o) |=> busy_o);
    assert_src_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |-> (src_sel_i != 2'd3));
endmodule

// File: tb/freq_meas_seq_bench.sv
module freq_meas_seq_bench;
    localparam int CLK_HZ  = 4_000_000;
    localparam int CYC_US  = CLK_HZ / 1_000_000;
    localparam int SCALE_W = 16;
    localparam int DUR_W   = 8;
    localparam int NUM_W   = SCALE_W + 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] src_sel = '0;
    logic [SCALE_W-1:0] scale = '0;
    logic [DUR_W-1:0] dur = '0;
    logic busy, req, valid;
    logic [1:0] op;
    logic [7:0] addr, mask;
    logic ack = 1'b0;
    logic [7:0] rdata = '0;
    logic [NUM_W-1:0] result;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    longint open_cyc = 0;
    longint last_exp = 0;

    logic [17:0] exp_ops[$];
    logic [7:0]  exp_rd[$];
    longint      exp_gap[$];
    longint      exp_res[$];

    always #10 clk = ~clk;

    freq_meas_seq #(.CLK_HZ(CLK_HZ), .SCALE_W(SCALE_W), .DUR_W(DUR_W)) u_freq_meas_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .src_sel_i(src_sel),
        .scale_i(scale), .dur_ms_i(dur), .busy_o(busy), .reg_req_o(req),
        .reg_op_o(op), .reg_addr_o(addr), .reg_mask_o(mask), .reg_ack_i(ack),
        .reg_rdata_i(rdata), .result_o(result), .result_valid_o(valid)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Register model: acknowledges one operation per request and compares it.
    initial forever begin
        @(negedge clk);
        if (ack) begin
            ack = 1'b0;
        end else if (req) begin
            logic [17:0] got;
            got = {op, addr, mask};
            if (exp_ops.size() == 0) begin
                check(1'b0, "R3 unexpected operation", longint'(got), 0);
            end else begin
                logic [17:0] want;
                want = exp_ops.pop_front();
                check(got == want, "R3/R6/R7 operation order", longint'(got), longint'(want));
            end
            if (got == {2'd0, 8'h06, 8'h04}) open_cyc = cyc;
            if (got == {2'd1, 8'h06, 8'h04} && exp_gap.size() > 0) begin
                longint g;
                g = exp_gap.pop_front();
                check((cyc - open_cyc) == g, "R5 gate length", cyc - open_cyc, g);
            end
            if (op == 2'd2 && exp_rd.size() > 0) rdata = exp_rd.pop_front();
            ack = 1'b1;
        end
    end

    // Monitor: compares each result strobe with the scoreboard.
    initial forever begin
        @(negedge clk);
        if (valid) begin
            if (exp_res.size() == 0) begin
                check(1'b0, "R9 unexpected valid", longint'(result), 0);
            end else begin
                longint e;
                e = exp_res.pop_front();
                check(longint'(result) == e, "R8 scaled result", longint'(result), e);
            end
        end
    end

    task automatic measure(input int s, input int sc, input int d, input int count, input bit disturb);
        logic [7:0] m;
        longint num;
        m = 8'(1) << s;
        while (busy) @(negedge clk);
        exp_ops.push_back({2'd0, 8'h02, m});
        exp_ops.push_back({2'd1, 8'h06, 8'h02});
        exp_ops.push_back({2'd0, 8'h12, 8'h80});
        exp_ops.push_back({2'd0, 8'h06, 8'h80});
        exp_ops.push_back({2'd1, 8'h06, 8'h80});
        exp_ops.push_back({2'd0, 8'h06, 8'h04});
        exp_ops.push_back({2'd1, 8'h06, 8'h04});
        exp_ops.push_back({2'd2, 8'h0B, 8'h00});
        exp_ops.push_back({2'd2, 8'h0A, 8'h00});
        exp_ops.push_back({2'd1, 8'h12, 8'h80});
        exp_ops.push_back({2'd1, 8'h02, m});
        exp_rd.push_back(8'(count >> 8));
        exp_rd.push_back(8'(count));
        exp_gap.push_back(longint'(d * 1000 - 16) * CYC_US + 1);
        num = longint'(sc) * longint'(count) * ((s == 1) ? 256 : 1);
        last_exp = num / d;
        exp_res.push_back(last_exp);
        src_sel = 2'(s); scale = SCALE_W'(sc); dur = DUR_W'(d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: inputs changed after acceptance must not matter
        src_sel = 2'((s + 1) % 3); scale = 16'h5A5A; dur = 8'd9;
        check(busy == 1'b1, "R10 busy after start", longint'(busy), 1);
        if (disturb) begin
            repeat (6) @(negedge clk);
            start = 1'b1; src_sel = 2'd2; scale = 16'd3; dur = 8'd1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        check(exp_res.size() == 0, "R9 result delivered", exp_res.size(), 0);
        repeat (3) @(negedge clk);
        check(valid == 1'b0, "R9 valid is a pulse", longint'(valid), 0);
        check(longint'(result) == last_exp, "R9 result held", longint'(result), last_exp);
        check(exp_ops.size() == 0, "R7 all operations issued", exp_ops.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req == 1'b0,   "R1 req in reset",   longint'(req), 0);
        check(valid == 1'b0, "R1 valid in reset", longint'(valid), 0);
        check(busy == 1'b0,  "R1 busy in reset",  longint'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req == 1'b0 && busy == 1'b0, "R1 idle after reset", longint'(busy), 0);
        measure(1, 1, 1, 16'h1234, 1'b0);
        measure(0, 1000, 2, 16'hBEEF, 1'b1);
        measure(2, 1000, 3, 12345, 1'b0);
        measure(1, 3, 7, 16'hFFFF, 1'b0);
        measure(0, 65535, 1, 16'hFFFF, 1'b0);
        measure(2, 500, 1, 0, 1'b1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end
endmodule